// File: doc/BRIEF.md
# Periodic Down-Counter Timer with Compare Output

This block is a timer peripheral with a 32-bit down-counter behind a small synchronous register bus. A control word chooses one of three tick inputs (or none), divides the chosen tick by a 12-bit prescaler, and picks how the counter behaves. The counter steps down by one on each divided tick. When it reaches zero, it either reloads from the load register or wraps to all ones.

On the tick where the counter equals the compare register, the block sets a sticky match flag. It raises an interrupt when that flag is enabled, and it updates a compare output pin in one of four ways.

Software can restart or resume the count when enabling the timer. It can make load writes overwrite the counter at once. It can choose whether counting carries on while the chip is in wait, stop or debug state. It can also reset the whole block with a self-clearing control bit. The three tick inputs are single-cycle enables that are already in the block's clock domain.

Top module: `pdt_timer`

## Requirements
- R1: After reset, the control, status, load, compare and counter registers all read 0, and irq, cmp_out and cmp_oe are low.
- R2: Control bits [10:9] select the tick source. 0 means no counting, 1 is tick_periph, 2 is tick_hf and 3 is tick_lf.
- R3: Control bits [24:13] hold a prescale value P. While the timer runs, the counter decrements once every P+1 selected ticks. The prescaler restarts from zero when the timer is enabled, so the first step comes P+1 ticks after the enabling write.
- R4: With control bit 2 set (reload mode), a tick at count 0 loads the load register into the counter. With bit 2 clear (free-running), a tick at count 0 wraps the counter to 0xFFFF_FFFF.
- R5: A write that sets enable (control bit 0) while it is clear starts the count. If control bit 1 is set, the count starts fresh: from the load value in reload mode, or from 0xFFFF_FFFF in free-running mode. If bit 1 is clear, the count resumes from the value it held.
- R6: With control bit 4 set, a write to the load register also writes the counter on the same edge. With bit 4 clear, a load write leaves the counter unchanged.
- R7: On a counting tick where the counter equals the compare register, status bit 0 is set. The bit stays set until software writes status with bit 0 at 1. Writing 0 to it has no effect.
- R8: irq is high in the cycle after status bit 0 and control bit 3 (interrupt enable) are both set. Otherwise irq is low.
- R9: Control bits [12:11] set the pin action on a match. 0 holds cmp_out and drives cmp_oe low. 1 toggles cmp_out, 2 drives it low and 3 drives it high. cmp_out changes on the same edge that sets the flag.
- R10: Counting freezes, and the counter keeps its value, while wait_in, stop_in or dbg_in is high and its allow bit (control bits 5, 6, 7 respectively) is clear. When the allow bit is set, counting continues.
- R11: Writing control bit 8 resets every register to its reset value. Bit 8 reads as 1 for SWR_CYC cycles and then clears by itself.
- R12: Bus addresses are 0 control, 1 status, 2 load, 3 compare and 4 counter. bus_rdata shows the addressed register one clock after the address is presented. Writes to the counter address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Registered read data |
| tick_periph | input | 1 | Tick source 1 enable |
| tick_hf | input | 1 | Tick source 2 enable |
| tick_lf | input | 1 | Tick source 3 enable |
| wait_in | input | 1 | Chip is in wait state |
| stop_in | input | 1 | Chip is in stop state |
| dbg_in | input | 1 | Chip is halted for debug |
| cmp_out | output | 1 | Compare output pin value |
| cmp_oe | output | 1 | Compare output pin enable |
| irq | output | 1 | Compare-match interrupt |

## Verification
The bench builds the block with its defaults: CNT_W=32, PRE_W=12 and SWR_CYC=4.

At full width the wrap to all ones can be reached in a few cycles. To do this, the bench first loads a small value through the overwrite path and then lets the counter cross zero.

The 12-bit prescaler can be run at its largest value, 4095, within a short run. This shows the full range of the divider field.

The four-cycle software reset is long enough to read the busy bit while it is set, and short enough to confirm that it clears.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADR_CTRL = 0;
  localparam int ADR_STAT = 1;
  localparam int ADR_LOAD = 2;
  localparam int ADR_CMP  = 3;
  localparam int ADR_CNT  = 4;

  localparam int B_EN     = 0;
  localparam int B_FRESH  = 1;
  localparam int B_RLD    = 2;
  localparam int B_IRQEN  = 3;
  localparam int B_OW     = 4;
  localparam int B_WAITEN = 5;
  localparam int B_STOPEN = 6;
  localparam int B_DBGEN  = 7;
  localparam int B_SWR    = 8;
  localparam int B_SRC    = 9;
  localparam int B_OM     = 11;
  localparam int B_PRE    = 13;

  typedef enum logic [1:0] {SRC_OFF, SRC_PERIPH, SRC_HF, SRC_LF} src_e;
  typedef enum logic [1:0] {OM_NONE, OM_TOGGLE, OM_LOW, OM_HIGH} omode_e;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       src_sel,
  input  logic             tick_periph,
  input  logic             tick_hf,
  input  logic             tick_lf,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] presc,
  output logic             tick
);
  import tmr_pkg::*;
  logic [PRE_W-1:0] pcnt;
  logic             src_tick;
  logic             active;

  always_comb begin
    case (src_e'(src_sel))
      SRC_PERIPH: src_tick = tick_periph;
      SRC_HF:     src_tick = tick_hf;
      SRC_LF:     src_tick = tick_lf;
      default:    src_tick = 1'b0;
    endcase
  end

  assign active = run & src_tick;
  assign tick   = active & (pcnt == presc);

  always_ff @(posedge clk) begin
    if (rst || restart) pcnt <= '0;
    else if (active)    pcnt <= tick ? '0 : pcnt + 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             reload_mode,
  input  logic             ld_ow,
  input  logic [CNT_W-1:0] ow_val,
  input  logic [CNT_W-1:0] load_val,
  input  logic             start,
  input  logic             start_fresh,
  input  logic             start_reload,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt,
  output logic             match
);
  assign match = tick & (cnt == cmp_val);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (ld_ow)
      cnt <= ow_val;
    else if (start) begin
      if (start_fresh) cnt <= start_reload ? load_val : '1;
    end else if (tick)
      cnt <= (cnt == '0) ? (reload_mode ? load_val : '1) : cnt - 1'b1;
  end
endmodule

// File: rtl/tmr_cmp_out.sv
module tmr_cmp_out (
  input  logic       clk,
  input  logic       rst,
  input  logic       match,
  input  logic [1:0] omode,
  input  logic       irq_en,
  input  logic       flag_clr,
  output logic       flag,
  output logic       pin,
  output logic       oe,
  output logic       irq
);
  import tmr_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      pin  <= 1'b0;
      oe   <= 1'b0;
      irq  <= 1'b0;
    end else begin
      oe  <= (omode_e'(omode) != OM_NONE);
      irq <= irq_en & flag;
      if (match)         flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
      if (match) begin
        case (omode_e'(omode))
          OM_TOGGLE: pin <= ~pin;
          OM_LOW:    pin <= 1'b0;
          OM_HIGH:   pin <= 1'b1;
          default:   pin <= pin;
        endcase
      end
    end
  end
endmodule

// File: rtl/pdt_timer.sv
module pdt_timer #(
  parameter int CNT_W   = 32,
  parameter int PRE_W   = 12,
  parameter int ADDR_W  = 3,
  parameter int SWR_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              tick_periph,
  input  logic              tick_hf,
  input  logic              tick_lf,
  input  logic              wait_in,
  input  logic              stop_in,
  input  logic              dbg_in,
  output logic              cmp_out,
  output logic              cmp_oe,
  output logic              irq
);
  import tmr_pkg::*;
  localparam int CTRL_W = B_PRE + PRE_W;
  localparam int SWR_W  = $clog2(SWR_CYC + 1);

  logic [SWR_W-1:0]  swr_cnt;
  logic              swr_busy, rst_i;
  logic [CTRL_W-1:0] ctrl_q, ctrl_rd;
  logic [CNT_W-1:0]  load_q, cmp_q, cnt;
  logic              wr_ok, ctrl_wr, ld_wr, ld_ow, st_clr;
  logic              en_rise, psc_restart, frozen, run, tick, match, flag_q;
  logic [PRE_W-1:0]  presc;

  assign swr_busy = (swr_cnt != '0);
  assign rst_i    = rst | swr_busy;
  assign wr_ok    = bus_we & ~swr_busy;
  assign ctrl_wr  = wr_ok & (bus_addr == ADDR_W'(ADR_CTRL));
  assign ld_wr    = wr_ok & (bus_addr == ADDR_W'(ADR_LOAD));
  assign ld_ow    = ld_wr & ctrl_q[B_OW];
  assign st_clr   = wr_ok & (bus_addr == ADDR_W'(ADR_STAT)) & bus_wdata[0];
  assign presc    = ctrl_q[B_PRE +: PRE_W];

  assign en_rise     = ctrl_wr & bus_wdata[B_EN] & ~ctrl_q[B_EN];
  assign psc_restart = en_rise | (ctrl_wr & (bus_wdata[B_PRE +: PRE_W] != presc));
  assign frozen = (wait_in & ~ctrl_q[B_WAITEN]) | (stop_in & ~ctrl_q[B_STOPEN]) |
                  (dbg_in & ~ctrl_q[B_DBGEN]);
  assign run    = ctrl_q[B_EN] & ~frozen;

  always_ff @(posedge clk) begin
    if (rst)                             swr_cnt <= '0;
    else if (swr_busy)                   swr_cnt <= swr_cnt - 1'b1;
    else if (ctrl_wr && bus_wdata[B_SWR]) swr_cnt <= SWR_W'(SWR_CYC);
  end

  always_ff @(posedge clk) begin
    if (rst_i) begin
      ctrl_q <= '0;
      load_q <= '0;
      cmp_q  <= '0;
    end else if (wr_ok) begin
      if (bus_addr == ADDR_W'(ADR_CTRL)) begin
        ctrl_q        <= bus_wdata[CTRL_W-1:0];
        ctrl_q[B_SWR] <= 1'b0;
      end
      if (bus_addr == ADDR_W'(ADR_LOAD)) load_q <= bus_wdata;
      if (bus_addr == ADDR_W'(ADR_CMP))  cmp_q  <= bus_wdata;
    end
  end

  always_comb begin
    ctrl_rd        = ctrl_q;
    ctrl_rd[B_SWR] = swr_busy;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        ADDR_W'(ADR_CTRL): bus_rdata <= CNT_W'(ctrl_rd);
        ADDR_W'(ADR_STAT): bus_rdata <= CNT_W'(flag_q);
        ADDR_W'(ADR_LOAD): bus_rdata <= load_q;
        ADDR_W'(ADR_CMP):  bus_rdata <= cmp_q;
        ADDR_W'(ADR_CNT):  bus_rdata <= cnt;
        default:           bus_rdata <= '0;
      endcase
    end
  end

  tmr_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk(clk), .rst(rst_i), .src_sel(ctrl_q[B_SRC +: 2]),
    .tick_periph(tick_periph), .tick_hf(tick_hf), .tick_lf(tick_lf),
    .run(run), .restart(psc_restart), .presc(presc), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst_i), .tick(tick), .reload_mode(ctrl_q[B_RLD]),
    .ld_ow(ld_ow), .ow_val(bus_wdata), .load_val(load_q),
    .start(en_rise), .start_fresh(bus_wdata[B_FRESH]), .start_reload(bus_wdata[B_RLD]),
    .cmp_val(cmp_q), .cnt(cnt), .match(match)
  );

  tmr_cmp_out u_out (
    .clk(clk), .rst(rst_i), .match(match), .omode(ctrl_q[B_OM +: 2]),
    .irq_en(ctrl_q[B_IRQEN]), .flag_clr(st_clr), .flag(flag_q),
    .pin(cmp_out), .oe(cmp_oe), .irq(irq)
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             tick,
  input logic             match,
  input logic             flag,
  input logic             irq,
  input logic             cmp_out,
  input logic [1:0]       omode,
  input logic             reload,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] load,
  input logic [CNT_W-1:0] wdata,
  input logic             frozen,
  input logic             ld_ow,
  input logic             en_rise
);
  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (rst || busy)
    match |=> flag);
  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst || busy)
    !flag |=> !irq);
  // R9
  pin_toggle_chk: assert property (@(posedge clk) disable iff (rst || busy)
    (match && omode == 2'd1) |=> (cmp_out != $past(cmp_out)));
  // R9
  pin_high_chk: assert property (@(posedge clk) disable iff (rst || busy)
    (match && omode == 2'd3) |=> cmp_out);
  // R9
  pin_low_chk: assert property (@(posedge clk) disable iff (rst || busy)
    (match && omode == 2'd2) |=> !cmp_out);
  // R4
  reload_chk: assert property (@(posedge clk) disable iff (rst || busy)
    (tick && cnt == '0 && reload && !ld_ow) |=> (cnt == $past(load)));
  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (rst || busy)
    (tick && cnt == '0 && !reload && !ld_ow) |=> (cnt == '1));
  // R10
  frozen_hold_chk: assert property (@(posedge clk) disable iff (rst || busy)
    (frozen && !ld_ow && !en_rise) |=> $stable(cnt));
  // R6
  overwrite_chk: assert property (@(posedge clk) disable iff (rst || busy)
    ld_ow |=> (cnt == $past(wdata)));
endmodule

bind pdt_timer tmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .busy(swr_busy), .tick(tick), .match(match),
  .flag(flag_q), .irq(irq), .cmp_out(cmp_out), .omode(ctrl_q[11 +: 2]),
  .reload(ctrl_q[2]), .cnt(cnt), .load(load_q), .wdata(bus_wdata),
  .frozen(frozen), .ld_ow(ld_ow), .en_rise(en_rise)
);

// File: tb/sim_pdt_timer.sv
module sim_pdt_timer;
  localparam int CLK_P = 10;
  localparam int W     = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic          tick_periph = 1'b1, tick_hf = 1'b0, tick_lf = 1'b1;
  logic          wait_in = 1'b0, stop_in = 1'b0, dbg_in = 1'b0;
  logic          cmp_out, cmp_oe, irq;
  int            n_chk = 0, n_fail = 0;
  bit            done = 0;
  logic [W-1:0]  v;

  pdt_timer u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_periph(tick_periph),
    .tick_hf(tick_hf), .tick_lf(tick_lf), .wait_in(wait_in), .stop_in(stop_in),
    .dbg_in(dbg_in), .cmp_out(cmp_out), .cmp_oe(cmp_oe), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct packed {
    logic        rld;
    logic [11:0] p;
    logic [31:0] l;
    logic [15:0] k;
    logic [31:0] e;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{1'b1, 12'd0,    32'd10,  16'd3,    32'd7},
    '{1'b1, 12'd0,    32'd3,   16'd6,    32'd1},
    '{1'b1, 12'd2,    32'd100, 16'd10,   32'd97},
    '{1'b1, 12'd4,    32'd5,   16'd30,   32'd5},
    '{1'b0, 12'd0,    32'd7,   16'd5,    32'hFFFF_FFFA},
    '{1'b0, 12'd1,    32'd7,   16'd7,    32'hFFFF_FFFC},
    '{1'b1, 12'd4095, 32'd9,   16'd8192, 32'd7}
  };

  function automatic logic [W-1:0] ctl(bit en, bit fresh, bit rld, bit irqen,
                                       bit ow, int sel, int om, int p);
    logic [W-1:0] c;
    c = '0;
    c[0] = en; c[1] = fresh; c[2] = rld; c[3] = irqen; c[4] = ow;
    c[10:9]  = sel[1:0];
    c[12:11] = om[1:0];
    c[24:13] = p[11:0];
    return c;
  endfunction

  task automatic chk(string req, logic [W-1:0] got, logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(int a, logic [W-1:0] d);
    bus_addr = 3'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [W-1:0] d);
    bus_addr = 3'(a);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic run_cmp(int om, bit irqen, bit pin_before, bit pin_after, string req);
    wr(1, 32'd1);
    wr(0, 32'd0);
    dbg_in = 1'b0;
    wr(3, 32'd3);
    wr(2, 32'd5);
    wr(0, ctl(1, 1, 1, irqen, 0, 1, om, 0));
    @(negedge clk);
    @(negedge clk);
    chk({req, " pin before match"}, W'(cmp_out), W'(pin_before));
    chk({req, " R9 oe"}, W'(cmp_oe), W'(om != 0));
    @(negedge clk);
    chk({req, " pin at match"}, W'(cmp_out), W'(pin_after));
    dbg_in = 1'b1;
    @(negedge clk);
    chk("R8 irq follows flag and enable", W'(irq), W'(irqen));
    rd(1, v);
    chk("R7 flag set on match", v, 32'd1);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 32'd0);
    rd(1, v); chk("R1 status", v, 32'd0);
    rd(2, v); chk("R1 load", v, 32'd0);
    rd(4, v); chk("R1 counter", v, 32'd0);
    chk("R1 outputs", W'({irq, cmp_out, cmp_oe}), 32'd0);

    // R3 R4 R5 vector table
    foreach (VEC[i]) begin
      wr(0, 32'd0);
      dbg_in = 1'b0;
      wr(2, VEC[i].l);
      wr(0, ctl(1, 1, VEC[i].rld, 0, 0, 1, 0, int'(VEC[i].p)));
      repeat (int'(VEC[i].k)) @(negedge clk);
      dbg_in = 1'b1;
      rd(4, v);
      chk($sformatf("R3/R4 vector %0d", i), v, VEC[i].e);
    end

    // R2 source select
    wr(0, 32'd0); dbg_in = 1'b0; wr(2, 32'd20);
    wr(0, ctl(1, 1, 1, 0, 0, 0, 0, 0)); repeat (5) @(negedge clk);
    rd(4, v); chk("R2 source off", v, 32'd20);
    wr(0, 32'd0);
    wr(0, ctl(1, 1, 1, 0, 0, 2, 0, 0)); repeat (5) @(negedge clk);
    rd(4, v); chk("R2 idle hf source", v, 32'd20);
    wr(0, 32'd0);
    wr(0, ctl(1, 1, 1, 0, 0, 3, 0, 0)); repeat (5) @(negedge clk);
    dbg_in = 1'b1;
    rd(4, v); chk("R2 lf source", v, 32'd15);

    // R10 wait allowed, stop freezes
    wr(0, 32'd0); dbg_in = 1'b0; wait_in = 1'b1; wr(2, 32'd100);
    wr(0, ctl(1, 1, 1, 0, 0, 1, 0, 0) | 32'h20);
    repeat (4) @(negedge clk);
    stop_in = 1'b1;
    rd(4, v); chk("R10 wait allowed", v, 32'd96);
    repeat (5) @(negedge clk);
    rd(4, v); chk("R10 stop freezes", v, 32'd96);
    wait_in = 1'b0; stop_in = 1'b0; dbg_in = 1'b1;

    // R7 R8 R9 compare actions
    run_cmp(1, 1'b1, 1'b0, 1'b1, "R9 toggle");
    run_cmp(2, 1'b0, 1'b1, 1'b0, "R9 low");
    run_cmp(3, 1'b0, 1'b0, 1'b1, "R9 high");
    run_cmp(0, 1'b0, 1'b1, 1'b1, "R9 none");
    run_cmp(1, 1'b1, 1'b1, 1'b0, "R9 toggle back");
    wr(1, 32'd0);
    rd(1, v); chk("R7 write 0 keeps flag", v, 32'd1);
    wr(1, 32'd1);
    @(negedge clk);
    chk("R8 irq drops after clear", W'(irq), 32'd0);
    rd(1, v); chk("R7 flag cleared", v, 32'd0);

    // R6 R4 R5 overwrite, wrap, resume
    wr(0, 32'd0); dbg_in = 1'b0;
    wr(0, ctl(0, 0, 0, 0, 1, 1, 0, 0));
    wr(2, 32'd2);
    rd(4, v); chk("R6 overwrite on load write", v, 32'd2);
    wr(0, ctl(1, 0, 0, 0, 1, 1, 0, 0));
    repeat (3) @(negedge clk);
    dbg_in = 1'b1;
    rd(4, v); chk("R4 free-run wrap", v, 32'hFFFF_FFFF);
    wr(0, ctl(0, 0, 0, 0, 0, 1, 0, 0));
    wr(2, 32'd50);
    rd(4, v); chk("R6 no overwrite", v, 32'hFFFF_FFFF);
    wr(4, 32'd123);
    rd(4, v); chk("R12 counter write ignored", v, 32'hFFFF_FFFF);
    dbg_in = 1'b0;
    wr(0, ctl(1, 0, 0, 0, 0, 1, 0, 0));
    repeat (2) @(negedge clk);
    dbg_in = 1'b1;
    rd(4, v); chk("R5 resume", v, 32'hFFFF_FFFD);
    rd(3, v); chk("R12 compare readback", v, 32'd3);

    // R11 software reset
    wr(0, 32'h100 | ctl(1, 0, 1, 1, 0, 1, 1, 7));
    rd(0, v);
    rd(0, v); chk("R11 busy bit set", v, 32'h100);
    repeat (6) @(negedge clk);
    rd(0, v); chk("R11 busy bit clears", v, 32'd0);
    rd(2, v); chk("R11 load reset", v, 32'd0);
    rd(4, v); chk("R11 counter reset", v, 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule